// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a memory device. A four-bit state machine advances on each rising edge of the test clock under control of the mode-select line and routes one of four shift registers between the serial input and the serial output. The registers are a 3-bit instruction register, a 1-bit bypass cell, a 32-bit identification register and a boundary register of parameterised length. The low cells of the boundary register capture the device pin levels. The remaining cells are placeholders.

There is no dedicated test reset pin. The controller returns to its reset state at power-up (`por_n` low) and whenever the mode-select line is held high for five rising clock edges. In the reset state the instruction register reloads the identification instruction. One instruction asks the rest of the device to float its functional outputs, and the block raises `outs_hiz` while that instruction is current. The serial output is launched on the falling edge, so a downstream device can sample it safely on the next rising edge.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: While `por_n` is low, and after it is released, the controller is in the reset state and the current instruction is IDCODE (code 001). At that point `tdo_en` is 0 and `outs_hiz` is 0.
- R2: Five consecutive rising `tck` edges with `tms` high bring the controller to the reset state from any state. Entering the reset state presets the current instruction to IDCODE.
- R3: In the capture-instruction state the instruction shift register loads 001, with bits 1:0 equal to 01. These bits are the first to leave on `tdo`, least significant bit first.
- R4: A shifted instruction code becomes current only after the controller passes through the update-instruction state. Until then the previous instruction stays in force.
- R5: Under IDCODE (001) the data path is a 32-bit register. It captures the parameter `ID_VAL`, whose bit 0 is 1, and shifts it out least significant bit first.
- R6: Codes 111, 011, 101 and 110 all select the 1-bit bypass cell. This cell captures 0, so a shifted stream appears on `tdo` delayed by exactly one bit.
- R7: Under SAMPLE-Z (010) `outs_hiz` is 1 and the boundary register is the data path. Under every other instruction `outs_hiz` is 0.
- R8: Under EXTEST (000), SAMPLE/PRELOAD (100) and SAMPLE-Z (010) the boundary register is the data path. In the capture-data state, cell i loads `pin_lvl[i]` for i < `PIN_CNT`, and every higher cell loads 1.
- R9: `tdo` and `tdo_en` change only on falling `tck` edges. `tdo_en` is 1 only during the shift-data and shift-instruction states.
- R10: State changes follow the standard 16-state test-port diagram, driven by `tms` sampled on the rising edge of `tck`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-up reset, active low, asynchronous |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| pin_lvl | input | PIN_CNT | Levels of the device pins captured by the boundary register |
| tdo | output | 1 | Serial data out, launched on falling `tck` |
| tdo_en | output | 1 | Drive enable for `tdo`; 0 means the pin floats |
| outs_hiz | output | 1 | Request to float the device's functional outputs |

## Verification
The checks assume that `tms`, `tdi` and `pin_lvl` settle away from the rising edge of `tck`. They also assume that `por_n` is asserted once at power-up, before any test clock activity. The bench meets both assumptions by driving inputs two nanoseconds after each falling edge and holding `pin_lvl` constant across every capture. It keeps `por_n` low for several clocks before release. Random mode-select walks are free to visit any state, because the design must accept every `tms` sequence.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

    localparam int IR_W = 3;

    typedef enum logic [3:0] {
        ST_EX2_DR  = 4'h0,
        ST_EX1_DR  = 4'h1,
        ST_SH_DR   = 4'h2,
        ST_PAU_DR  = 4'h3,
        ST_SEL_IR  = 4'h4,
        ST_UPD_DR  = 4'h5,
        ST_CAP_DR  = 4'h6,
        ST_SEL_DR  = 4'h7,
        ST_EX2_IR  = 4'h8,
        ST_EX1_IR  = 4'h9,
        ST_SH_IR   = 4'hA,
        ST_PAU_IR  = 4'hB,
        ST_RTI     = 4'hC,
        ST_UPD_IR  = 4'hD,
        ST_CAP_IR  = 4'hE,
        ST_TLR     = 4'hF
    } tap_state_e;

    typedef enum logic [IR_W-1:0] {
        OP_EXTEST   = 3'b000,
        OP_IDCODE   = 3'b001,
        OP_SAMPLE_Z = 3'b010,
        OP_RSV_A    = 3'b011,
        OP_SAMPLE   = 3'b100,
        OP_PRIV     = 3'b101,
        OP_RSV_B    = 3'b110,
        OP_BYPASS   = 3'b111
    } tap_op_e;

    typedef enum logic [1:0] {
        SEL_BYP = 2'd0,
        SEL_ID  = 2'd1,
        SEL_BSR = 2'd2
    } dr_sel_e;

    function automatic dr_sel_e op_to_sel(input tap_op_e op);
        case (op)
            OP_EXTEST, OP_SAMPLE_Z, OP_SAMPLE: return SEL_BSR;
            OP_IDCODE:                         return SEL_ID;
            default:                           return SEL_BYP;
        endcase
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tms,
    output tap_state_e state_o
);

    typedef struct packed {
        tap_state_e st;
    } fsm_t;

    fsm_t d, q;

    always_comb begin
        d = q;
        case (q.st)
            ST_TLR:    d.st = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    d.st = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: d.st = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: d.st = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  d.st = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: d.st = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: d.st = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: d.st = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: d.st = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: d.st = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: d.st = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  d.st = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: d.st = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: d.st = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: d.st = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: d.st = tms ? ST_SEL_DR : ST_RTI;
            default:   d.st = ST_TLR;
        endcase
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) q <= '{st: ST_TLR};
        else        q <= d;
    end

    assign state_o = q.st;

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import jtag_tap_pkg::*;
(
    input  logic            tck,
    input  logic            por_n,
    input  logic            tdi,
    input  tap_state_e      state,
    output tap_op_e         op_o,
    output logic [IR_W-1:0] sr_o
);

    localparam logic [IR_W-1:0] CAP_PAT = {{(IR_W-2){1'b0}}, 2'b01};

    typedef struct packed {
        logic [IR_W-1:0] sr;
        tap_op_e         op;
    } ir_t;

    ir_t d, q;

    always_comb begin
        d = q;
        case (state)
            ST_TLR:    d.op = OP_IDCODE;
            ST_CAP_IR: d.sr = CAP_PAT;
            ST_SH_IR:  d.sr = {tdi, q.sr[IR_W-1:1]};
            ST_UPD_IR: d.op = tap_op_e'(q.sr);
            default:   d = q;
        endcase
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) q <= '{sr: CAP_PAT, op: OP_IDCODE};
        else        q <= d;
    end

    assign op_o = q.op;
    assign sr_o = q.sr;

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import jtag_tap_pkg::*;
#(
    parameter int          BSR_LEN = 16,
    parameter int          PIN_CNT = 12,
    parameter logic [31:0] ID_VAL  = 32'h1A5C_3E81
) (
    input  logic               tck,
    input  logic               por_n,
    input  logic               tdi,
    input  tap_state_e         state,
    input  dr_sel_e            sel,
    input  logic [PIN_CNT-1:0] pin_lvl,
    output logic               byp_o,
    output logic               dr_tdo
);

    localparam int ID_W = 32;

    typedef struct packed {
        logic               byp;
        logic [ID_W-1:0]    id;
        logic [BSR_LEN-1:0] bsr;
    } dr_t;

    dr_t d, q;
    logic [BSR_LEN-1:0] cap_vec;

    for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
        if (i < PIN_CNT) begin : g_pin
            assign cap_vec[i] = pin_lvl[i];
        end else begin : g_fill
            assign cap_vec[i] = 1'b1;
        end
    end

    always_comb begin
        d = q;
        if (state == ST_CAP_DR) begin
            case (sel)
                SEL_ID:  d.id  = ID_VAL;
                SEL_BSR: d.bsr = cap_vec;
                default: d.byp = 1'b0;
            endcase
        end else if (state == ST_SH_DR) begin
            case (sel)
                SEL_ID:  d.id  = {tdi, q.id[ID_W-1:1]};
                SEL_BSR: d.bsr = {tdi, q.bsr[BSR_LEN-1:1]};
                default: d.byp = tdi;
            endcase
        end
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (sel)
            SEL_ID:  dr_tdo = q.id[0];
            SEL_BSR: dr_tdo = q.bsr[0];
            default: dr_tdo = q.byp;
        endcase
    end

    assign byp_o = q.byp;

endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
    import jtag_tap_pkg::*;
#(
    parameter int          BSR_LEN = 16,
    parameter int          PIN_CNT = 12,
    parameter logic [31:0] ID_VAL  = 32'h1A5C_3E81
) (
    input  logic               tck,
    input  logic               por_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [PIN_CNT-1:0] pin_lvl,
    output logic               tdo,
    output logic               tdo_en,
    output logic               outs_hiz
);

    tap_state_e      state_q;
    tap_op_e         op_q;
    logic [IR_W-1:0] ir_sr_q;
    dr_sel_e         sel;
    logic            dr_tdo;
    logic            byp_q;

    typedef struct packed {
        logic tdo;
        logic en;
    } out_t;

    out_t d, q;

    tap_fsm u_fsm (
        .tck     (tck),
        .por_n   (por_n),
        .tms     (tms),
        .state_o (state_q)
    );

    tap_ir u_ir (
        .tck   (tck),
        .por_n (por_n),
        .tdi   (tdi),
        .state (state_q),
        .op_o  (op_q),
        .sr_o  (ir_sr_q)
    );

    assign sel = op_to_sel(op_q);

    tap_dr #(
        .BSR_LEN (BSR_LEN),
        .PIN_CNT (PIN_CNT),
        .ID_VAL  (ID_VAL)
    ) u_dr (
        .tck     (tck),
        .por_n   (por_n),
        .tdi     (tdi),
        .state   (state_q),
        .sel     (sel),
        .pin_lvl (pin_lvl),
        .byp_o   (byp_q),
        .dr_tdo  (dr_tdo)
    );

    always_comb begin
        d = q;
        d.en  = (state_q == ST_SH_DR) || (state_q == ST_SH_IR);
        d.tdo = 1'b0;
        if (state_q == ST_SH_IR)      d.tdo = ir_sr_q[0];
        else if (state_q == ST_SH_DR) d.tdo = dr_tdo;
    end

    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) q <= '0;
        else        q <= d;
    end

    assign tdo      = q.tdo;
    assign tdo_en   = q.en;
    assign outs_hiz = (op_q == OP_SAMPLE_Z);

endmodule

// File: rtl/jtag_tap_ctrl_chk.sv
module jtag_tap_ctrl_chk
    import jtag_tap_pkg::*;
(
    input logic            tck,
    input logic            por_n,
    input logic            tms,
    input logic            tdo_en,
    input logic            outs_hiz,
    input tap_state_e      state,
    input tap_op_e         op,
    input logic [IR_W-1:0] ir_sr,
    input logic            byp,
    input dr_sel_e         sel
);

    logic [2:0] ones_q;

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)              ones_q <= 3'd0;
        else if (!tms)           ones_q <= 3'd0;
        else if (ones_q != 3'd5) ones_q <= ones_q + 3'd1;
    end

    // R2
    five_ones_reset_chk: assert property (@(posedge tck) disable iff (!por_n)
        (ones_q == 3'd5) |-> (state == ST_TLR));

    // R1
    reset_preset_chk: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_TLR) |=> (op == OP_IDCODE));

    // R3
    ir_capture_chk: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_CAP_IR) |=> (ir_sr[1:0] == 2'b01));

    // R4
    op_update_chk: assert property (@(posedge tck) disable iff (!por_n)
        (op != $past(op)) |-> ($past(state) == ST_UPD_IR || $past(state) == ST_TLR));

    // R6
    byp_capture_chk: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_CAP_DR && sel == SEL_BYP) |=> (byp == 1'b0));

    // R7
    hiz_op_chk: assert property (@(posedge tck) disable iff (!por_n)
        outs_hiz |-> (sel == SEL_BSR));

    // R9
    tdo_en_shift_chk: assert property (@(posedge tck) disable iff (!por_n)
        tdo_en |-> (state == ST_SH_DR || state == ST_SH_IR));

endmodule

bind jtag_tap_ctrl jtag_tap_ctrl_chk u_chk (
    .tck      (tck),
    .por_n    (por_n),
    .tms      (tms),
    .tdo_en   (tdo_en),
    .outs_hiz (outs_hiz),
    .state    (state_q),
    .op       (op_q),
    .ir_sr    (ir_sr_q),
    .byp      (byp_q),
    .sel      (sel)
);

// File: tb/tb_jtag_tap_ctrl.sv
`timescale 1ns/1ps
module tb_jtag_tap_ctrl;
    import jtag_tap_pkg::*;

    localparam int          BSR_LEN = 16;
    localparam int          PIN_CNT = 12;
    localparam logic [31:0] ID_VAL  = 32'h1A5C_3E81;

    logic tck = 1'b0;
    logic por_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b1;
    logic [PIN_CNT-1:0] pin_lvl = '0;
    logic tdo, tdo_en, outs_hiz;

    always #5 tck = ~tck;

    jtag_tap_ctrl #(.BSR_LEN(BSR_LEN), .PIN_CNT(PIN_CNT), .ID_VAL(ID_VAL)) dut (
        .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .pin_lvl(pin_lvl),
        .tdo(tdo), .tdo_en(tdo_en), .outs_hiz(outs_hiz)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int r9_bad  = 0;
    logic s_tdo, s_en, s_hiz;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one test clock: sample outputs after the falling edge, drive inputs, take the rising edge
    task automatic tick(input logic m, input logic din);
        @(negedge tck);
        #2;
        s_tdo = tdo; s_en = tdo_en; s_hiz = outs_hiz;
        tms = m; tdi = din;
        @(posedge tck);
        #1;
        if (tdo !== s_tdo || tdo_en !== s_en) r9_bad++;
    endtask

    // from Run-Test/Idle through a data scan back to Run-Test/Idle
    task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout, output logic en_all);
        tick(1'b1, 1'b1);
        tick(1'b0, 1'b1);
        tick(1'b0, 1'b1);
        dout = '0;
        en_all = 1'b1;
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, din[i]);
            dout[i] = s_tdo;
            en_all &= s_en;
        end
        tick(1'b1, 1'b1);
        tick(1'b0, 1'b1);
    endtask

    task automatic shift_ir(input logic [2:0] code, output logic [2:0] cap, output logic hiz_at_upd);
        tick(1'b1, 1'b1);
        tick(1'b1, 1'b1);
        tick(1'b0, 1'b1);
        tick(1'b0, 1'b1);
        for (int i = 0; i < 3; i++) begin
            tick(i == 2, code[i]);
            cap[i] = s_tdo;
        end
        tick(1'b1, 1'b1);
        tick(1'b0, 1'b1);
        hiz_at_upd = s_hiz;
    endtask

    function automatic tap_state_e nxt(input tap_state_e s, input logic m);
        case (s)
            ST_TLR:    return m ? ST_TLR    : ST_RTI;
            ST_RTI:    return m ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: return m ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: return m ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
            default:   return m ? ST_SEL_DR : ST_RTI;
        endcase
    endfunction

    function automatic logic [BSR_LEN-1:0] bsr_expect(input logic [PIN_CNT-1:0] p);
        logic [BSR_LEN-1:0] v;
        v = '1;
        v[PIN_CNT-1:0] = p;
        return v;
    endfunction

    initial begin
        #2_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] dout, din;
        logic [2:0]  cap;
        logic        en_all, hz;
        logic [2:0]  byp_codes [4];
        tap_state_e  st_m;
        int unsigned seed;
        seed = 32'd2024;
        void'($urandom(seed));
        byp_codes[0] = 3'b111; byp_codes[1] = 3'b011;
        byp_codes[2] = 3'b101; byp_codes[3] = 3'b110;

        // R1: reset state
        repeat (4) @(posedge tck);
        #1;
        check(tdo_en == 1'b0, "R1 tdo_en in reset", 64'(tdo_en), 0);
        check(outs_hiz == 1'b0, "R1 outs_hiz in reset", 64'(outs_hiz), 0);
        @(negedge tck);
        por_n = 1'b1;

        // R1/R5: default instruction after power-up is IDCODE
        tick(1'b0, 1'b1);
        shift_dr(32, 64'h0, dout, en_all);
        check(dout[31:0] == ID_VAL, "R5 id value after power-up (R1)", dout, 64'(ID_VAL));
        check(dout[0] == 1'b1, "R5 id bit 0", 64'(dout[0]), 1);
        check(en_all == 1'b1, "R9 tdo_en during shift", 64'(en_all), 1);
        tick(1'b0, 1'b1);
        check(s_en == 1'b0, "R9 tdo_en in idle", 64'(s_en), 0);

        // R3: capture pattern of the instruction register
        shift_ir(3'b111, cap, hz);
        check(cap == 3'b001, "R3 ir capture", 64'(cap), 64'h1);

        // R6: every bypass-class code gives a one-bit delay
        foreach (byp_codes[k]) begin
            shift_ir(byp_codes[k], cap, hz);
            din = 64'($urandom) & 64'hFF;
            shift_dr(8, din, dout, en_all);
            check(dout[7:0] == {din[6:0], 1'b0}, $sformatf("R6 bypass code %b", byp_codes[k]),
                  dout, {56'h0, din[6:0], 1'b0});
        end

        // R8: boundary capture under EXTEST and SAMPLE/PRELOAD
        pin_lvl = PIN_CNT'($urandom);
        shift_ir(3'b000, cap, hz);
        shift_dr(BSR_LEN, 64'h0, dout, en_all);
        check(dout[BSR_LEN-1:0] == bsr_expect(pin_lvl), "R8 capture extest", dout, 64'(bsr_expect(pin_lvl)));
        check(outs_hiz == 1'b0, "R7 no hiz under extest", 64'(outs_hiz), 0);
        pin_lvl = PIN_CNT'($urandom);
        shift_ir(3'b100, cap, hz);
        shift_dr(BSR_LEN, 64'h0, dout, en_all);
        check(dout[BSR_LEN-1:0] == bsr_expect(pin_lvl), "R8 capture sample", dout, 64'(bsr_expect(pin_lvl)));

        // R4/R7: SAMPLE-Z takes effect only after update
        pin_lvl = PIN_CNT'($urandom);
        shift_ir(3'b010, cap, hz);
        check(hz == 1'b0, "R4 hiz not before update", 64'(hz), 0);
        check(outs_hiz == 1'b1, "R7 hiz under sample-z", 64'(outs_hiz), 1);
        shift_dr(BSR_LEN, 64'h0, dout, en_all);
        check(dout[BSR_LEN-1:0] == bsr_expect(pin_lvl), "R7 bsr path under sample-z (R8)", dout, 64'(bsr_expect(pin_lvl)));
        shift_ir(3'b111, cap, hz);
        check(hz == 1'b1, "R4 old op held until update", 64'(hz), 1);
        check(outs_hiz == 1'b0, "R7 hiz released", 64'(outs_hiz), 0);

        // R2: five TMS-high clocks from idle clear SAMPLE-Z
        shift_ir(3'b010, cap, hz);
        repeat (5) tick(1'b1, 1'b1);
        check(outs_hiz == 1'b0, "R2 reset clears sample-z", 64'(outs_hiz), 0);
        tick(1'b0, 1'b1);
        shift_dr(32, 64'h0, dout, en_all);
        check(dout[31:0] == ID_VAL, "R2 idcode preset after reset", dout, 64'(ID_VAL));

        // R2: five TMS-high clocks from the middle of a data shift
        shift_ir(3'b111, cap, hz);
        tick(1'b1, 1'b1); tick(1'b0, 1'b1); tick(1'b0, 1'b1); tick(1'b0, 1'b0);
        repeat (5) tick(1'b1, 1'b1);
        tick(1'b0, 1'b1);
        shift_dr(32, 64'h0, dout, en_all);
        check(dout[31:0] == ID_VAL, "R2 reset from shift-dr", dout, 64'(ID_VAL));

        // R10/R9: random walk of the mode-select line against a state model
        st_m = ST_RTI;
        for (int i = 0; i < 600; i++) begin
            logic m;
            m = ($urandom % 5) < 2;
            tick(m, 1'($urandom));
            check(s_en == (st_m == ST_SH_DR || st_m == ST_SH_IR), "R10 state walk tdo_en",
                  64'(s_en), 64'(st_m == ST_SH_DR || st_m == ST_SH_IR));
            st_m = nxt(st_m, m);
        end
        repeat (5) tick(1'b1, 1'b1);
        tick(1'b0, 1'b1);
        shift_dr(32, 64'h0, dout, en_all);
        check(dout[31:0] == ID_VAL, "R2 reset after random walk", dout, 64'(ID_VAL));

        // R9: outputs never moved on a rising edge
        check(r9_bad == 0, "R9 tdo changed off the falling edge", 64'(r9_bad), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule